// File: doc/BRIEF.md
# Start-up Clock Release Sequencer

This block decides when the core of a small controller may receive its system clock and when its internal reset may end. It runs from the 32 kHz reference clock. After the reset pin is released, or after a wake event ends a power-down, it counts reference cycles while the crystal oscillator starts and the frequency-multiplying loop settles. Only then does it enable the core clock.

The wait length depends on the oscillator. If the oscillator was stopped during power-down, it must start again, so the long wait applies. If it was kept alive, only the short loop-settling wait applies. After a pin reset, the core reset stays asserted for a few extra reference cycles once the clock runs, so the core initialises on a live clock. A wake never asserts the core reset; it only gates the clock off and then releases it.

The block also drives the control that tristates the oscillator inverter and pulls its input low. All wait lengths are parameters in reference cycles, so a short simulation can use small values.

Top module: `clk_release_seq`

## Requirements
- R1: While `rst_in` is high, `clk_en` is 0, `core_rst` is 1 and `osc_hold` is 1.
- R2: A high pulse on `rst_in` shorter than one reference period is still captured, and it causes the full start-up sequence. The pin's release passes through `SYNC_STAGES` flip-flops.
- R3: After `rst_in` falls, `clk_en` first reads 1 after the rising edge numbered `SYNC_STAGES+1+OSC_WAIT_CYC+PLL_WAIT_CYC`. Edges are counted from the first rising edge after the release.
- R4: After a reset sequence, `core_rst` stays 1 for exactly `OVERLAP_CYC` edges after `clk_en` rises. It falls only while `clk_en` is 1.
- R5: `pd_enter` sampled high while running sets `clk_en` to 0 after that edge. `pd_enter` is ignored in every other state.
- R6: A wake while parked with `keep32_on` high gives `clk_en` = 1 after the edge numbered `1+PLL_WAIT_CYC`, where the edge that samples `wake_req` is number 1.
- R7: A wake while parked with `keep32_on` low gives `clk_en` = 1 after the edge numbered `1+OSC_WAIT_CYC+PLL_WAIT_CYC`.
- R8: A wake never asserts `core_rst`. It stays 0 from power-down entry until the clock runs again.
- R9: `osc_hold` is 1 exactly when `rst_in` is 1, or `alt_osc_sel` is 1, or the block is parked in power-down with `keep32_on` low.
- R10: `wake_req` is ignored unless the block is parked in power-down. A wake while running leaves `clk_en` at 1, and a wake during a wait leaves the latency unchanged.
- R11: A reset in any state, including the middle of a wake wait, sets `clk_en` to 0 and `core_rst` to 1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 32 kHz reference clock |
| rst_in | input | 1 | Raw reset pin, active high, asynchronous |
| pd_enter | input | 1 | Core request to enter power-down, one reference cycle |
| wake_req | input | 1 | Wake event (enabled interrupt), level |
| keep32_on | input | 1 | 1: reference oscillator stays alive during power-down |
| alt_osc_sel | input | 1 | 1: the other crystal oscillator is selected |
| clk_en | output | 1 | Gate enable for the core system clock |
| core_rst | output | 1 | Stretched core reset, active high |
| osc_hold | output | 1 | Tristate the oscillator inverter and pull its input low |

## Verification
The release latency is measured edge by edge in three cases: after a pin reset, after a wake with the oscillator kept alive, and after a wake with it stopped. Each case has its own expected count, so swapping the long and short waits, or making an off-by-one error in a wait counter, shows up as a wrong count. A table also runs the two wake kinds with the alternate oscillator selected and deselected. This separates the three causes that drive `osc_hold`. Directed cases send `pd_enter` and `wake_req` during waits and while running, and cut a wake wait short with a reset pulse shorter than a clock period. These show that stray requests are ignored and that reset is captured asynchronously.

// File: rtl/strt_seq_pkg.sv
package strt_seq_pkg;

   typedef enum logic [2:0] {
      ST_HOLD     = 3'd0,
      ST_OSC_WAIT = 3'd1,
      ST_PLL_WAIT = 3'd2,
      ST_RST_OVLP = 3'd3,
      ST_RUN      = 3'd4
   } seq_state_t;

   function automatic logic state_clocked(input seq_state_t s);
      return (s == ST_RST_OVLP) || (s == ST_RUN);
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/strt_rst_sync.sv
module strt_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_async,
   output logic rst_sync
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or posedge rst_async) begin
               if (rst_async) chain[g] <= 1'b1;
               else           chain[g] <= 1'b0;
            end
         end else begin : g_next
            always_ff @(posedge clk or posedge rst_async) begin
               if (rst_async) chain[g] <= 1'b1;
               else           chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign rst_sync = chain[STAGES-1];
endmodule

// File: rtl/strt_wait_timer.sv
module strt_wait_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)              cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/strt_seq_fsm.sv
module strt_seq_fsm
   import strt_seq_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned OSC_WAIT_CYC = 20,
   parameter int unsigned PLL_WAIT_CYC = 6,
   parameter int unsigned OVERLAP_CYC  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pd_enter,
   input  logic             wake_req,
   input  logic             keep32_on,
   input  logic             tmr_zero,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output seq_state_t       state,
   output logic             rst_origin
);
   localparam logic [CNT_W-1:0] OSC_LD = CNT_W'(OSC_WAIT_CYC - 1);
   localparam logic [CNT_W-1:0] PLL_LD = CNT_W'(PLL_WAIT_CYC - 1);
   localparam logic [CNT_W-1:0] OVL_LD = CNT_W'(OVERLAP_CYC - 1);

   seq_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_HOLD: begin
            if (rst_origin)    nxt = ST_OSC_WAIT;
            else if (wake_req) nxt = keep32_on ? ST_PLL_WAIT : ST_OSC_WAIT;
         end
         ST_OSC_WAIT: if (tmr_zero) nxt = ST_PLL_WAIT;
         ST_PLL_WAIT: if (tmr_zero) nxt = rst_origin ? ST_RST_OVLP : ST_RUN;
         ST_RST_OVLP: if (tmr_zero) nxt = ST_RUN;
         ST_RUN:      if (pd_enter) nxt = ST_HOLD;
         default:     nxt = ST_HOLD;
      endcase
   end

   always_comb begin
      tmr_load = (nxt != state);
      unique case (nxt)
         ST_OSC_WAIT: tmr_val = OSC_LD;
         ST_PLL_WAIT: tmr_val = PLL_LD;
         ST_RST_OVLP: tmr_val = OVL_LD;
         default:     tmr_val = '0;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state      <= ST_HOLD;
         rst_origin <= 1'b1;
      end else begin
         state <= nxt;
         if (nxt == ST_RUN) rst_origin <= 1'b0;
      end
   end
endmodule

// File: rtl/clk_release_seq.sv
module clk_release_seq
   import strt_seq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned OSC_WAIT_CYC = 18317,
   parameter int unsigned PLL_WAIT_CYC = 33,
   parameter int unsigned OVERLAP_CYC  = 2
) (
   input  logic clk_ref,
   input  logic rst_in,
   input  logic pd_enter,
   input  logic wake_req,
   input  logic keep32_on,
   input  logic alt_osc_sel,
   output logic clk_en,
   output logic core_rst,
   output logic osc_hold
);
   localparam int unsigned MAX_CYC = max3(OSC_WAIT_CYC, PLL_WAIT_CYC, OVERLAP_CYC);
   localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (OSC_WAIT_CYC < 1 || PLL_WAIT_CYC < 1 || OVERLAP_CYC < 1) begin : g_bad_wait
         $error("wait counts must be at least 1");
      end
   endgenerate

   logic             rst_sync;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;
   seq_state_t       state;
   logic             rst_origin;

   strt_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk_ref),
      .rst_async (rst_in),
      .rst_sync  (rst_sync)
   );

   strt_wait_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk_ref),
      .rst      (rst_sync),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   strt_seq_fsm #(
      .CNT_W        (CNT_W),
      .OSC_WAIT_CYC (OSC_WAIT_CYC),
      .PLL_WAIT_CYC (PLL_WAIT_CYC),
      .OVERLAP_CYC  (OVERLAP_CYC)
   ) i_fsm (
      .clk        (clk_ref),
      .rst        (rst_sync),
      .pd_enter   (pd_enter),
      .wake_req   (wake_req),
      .keep32_on  (keep32_on),
      .tmr_zero   (tmr_zero),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .state      (state),
      .rst_origin (rst_origin)
   );

   logic parked;
   assign parked   = (state == ST_HOLD) && !rst_origin;
   assign clk_en   = state_clocked(state);
   assign core_rst = rst_origin;
   assign osc_hold = rst_in || alt_osc_sel || (parked && !keep32_on);
endmodule

// File: rtl/clk_release_seq_chk.sv
module clk_release_seq_chk (
   input logic clk_ref,
   input logic rst_in,
   input logic rst_sync,
   input logic pd_enter,
   input logic alt_osc_sel,
   input logic clk_en,
   input logic core_rst,
   input logic osc_hold
);
   assert_rst_ends_clocked_R4: assert property (@(posedge clk_ref)
      disable iff (rst_in || rst_sync) $fell(core_rst) |-> clk_en);

   assert_gate_only_on_pd_R5: assert property (@(posedge clk_ref)
      disable iff (rst_in || rst_sync) $fell(clk_en) |-> $past(pd_enter));

   assert_wake_no_reset_R8: assert property (@(posedge clk_ref)
      disable iff (rst_in || rst_sync) !$rose(core_rst));

   assert_hold_on_rst_or_alt_R9: assert property (@(posedge clk_ref)
      (rst_in || alt_osc_sel) |-> osc_hold);

   assert_clock_kept_R10: assert property (@(posedge clk_ref)
      disable iff (rst_in || rst_sync) (clk_en && !pd_enter) |=> clk_en);
endmodule

bind clk_release_seq clk_release_seq_chk i_chk (
   .clk_ref     (clk_ref),
   .rst_in      (rst_in),
   .rst_sync    (rst_sync),
   .pd_enter    (pd_enter),
   .alt_osc_sel (alt_osc_sel),
   .clk_en      (clk_en),
   .core_rst    (core_rst),
   .osc_hold    (osc_hold)
);

// File: tb/test_clk_release_seq.sv
`timescale 1ns/1ps
module test_clk_release_seq;
   localparam int SYNC = 2;
   localparam int OSC  = 20;
   localparam int PLL  = 6;
   localparam int OVL  = 3;
   localparam int RST_LAT   = SYNC + 1 + OSC + PLL;
   localparam int SHORT_LAT = 1 + PLL;
   localparam int LONG_LAT  = 1 + OSC + PLL;

   typedef struct packed {
      bit keep;
      bit alt;
      bit exp_hold;
   } vec_t;

   localparam vec_t VEC [4] = '{
      '{keep: 1'b1, alt: 1'b0, exp_hold: 1'b0},
      '{keep: 1'b0, alt: 1'b0, exp_hold: 1'b1},
      '{keep: 1'b1, alt: 1'b1, exp_hold: 1'b1},
      '{keep: 1'b0, alt: 1'b1, exp_hold: 1'b1}
   };

   logic clk = 1'b0;
   logic rst_in = 1'b0, pd_enter = 1'b0, wake_req = 1'b0;
   logic keep32_on = 1'b0, alt_osc_sel = 1'b0;
   logic clk_en, core_rst, osc_hold;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   clk_release_seq #(
      .SYNC_STAGES(SYNC), .OSC_WAIT_CYC(OSC), .PLL_WAIT_CYC(PLL), .OVERLAP_CYC(OVL)
   ) i_clk_release_seq (
      .clk_ref(clk), .rst_in(rst_in), .pd_enter(pd_enter), .wake_req(wake_req),
      .keep32_on(keep32_on), .alt_osc_sel(alt_osc_sel),
      .clk_en(clk_en), .core_rst(core_rst), .osc_hold(osc_hold)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // From release (inputs at negedge), count edges until clk_en is 1.
   // Optional stray pd_enter / wake_req pulses during the wait.
   task automatic count_release(output int n, input bit strays, input bit clear_wake);
      n = 0;
      while (n < 5000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (clear_wake) wake_req = 1'b0;
         pd_enter = strays && (n == 8);
         if (strays && n == 12) wake_req = 1'b1;
         if (strays && n == 13) wake_req = 1'b0;
         if (clk_en) break;
      end
      pd_enter = 1'b0;
   endtask

   task automatic count_overlap(output int m, output bit clk_dropped);
      m = 0;
      clk_dropped = 1'b0;
      while (core_rst && m < 5000) begin
         @(posedge clk);
         m++;
         @(negedge clk);
         if (!clk_en) clk_dropped = 1'b1;
      end
   endtask

   initial begin
      int n, m;
      bit dropped, rst_seen;
      #2 rst_in = 1'b1;
      @(negedge clk); @(negedge clk);
      // R1: reset state
      chk("R1 clk_en in reset", clk_en, 0);
      chk("R1 core_rst in reset", core_rst, 1);
      chk("R1 osc_hold in reset (R9)", osc_hold, 1);
      rst_in = 1'b0;
      #1 chk("R9 osc_hold after pin release", osc_hold, 0);
      // R3 latency, with stray pd_enter (R5) and wake (R10) during the wait
      count_release(n, 1'b1, 1'b0);
      chk("R3 R5 R10 reset release latency", n, RST_LAT);
      chk("R4 core_rst high at clock release", core_rst, 1);
      count_overlap(m, dropped);
      chk("R4 overlap length", m, OVL);
      chk("R4 clk_en held during overlap", dropped, 0);
      // R10: wake while running is ignored
      wake_req = 1'b1;
      repeat (3) @(negedge clk);
      wake_req = 1'b0;
      chk("R10 clk_en after wake in run", clk_en, 1);
      chk("R9 osc_hold in run", osc_hold, 0);

      // Table of wake cases
      foreach (VEC[i]) begin
         keep32_on = VEC[i].keep;
         alt_osc_sel = VEC[i].alt;
         pd_enter = 1'b1;
         @(negedge clk);
         pd_enter = 1'b0;
         chk("R5 clk_en gated after pd_enter", clk_en, 0);
         chk("R9 osc_hold while parked", osc_hold, VEC[i].exp_hold);
         chk("R8 core_rst while parked", core_rst, 0);
         wake_req = 1'b1;
         rst_seen = 1'b0;
         n = 0;
         while (n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            wake_req = 1'b0;
            if (core_rst) rst_seen = 1'b1;
            if (clk_en) break;
         end
         if (VEC[i].keep) chk("R6 short wake latency", n, SHORT_LAT);
         else             chk("R7 long wake latency", n, LONG_LAT);
         chk("R8 no core_rst during wake", rst_seen, 0);
         alt_osc_sel = 1'b0;
      end

      // R11 / R2: short reset pulse in the middle of a wake wait
      keep32_on = 1'b0;
      pd_enter = 1'b1;
      @(negedge clk);
      pd_enter = 1'b0;
      wake_req = 1'b1;
      @(negedge clk);
      wake_req = 1'b0;
      repeat (5) @(negedge clk);
      rst_in = 1'b1;
      #1;
      chk("R11 clk_en on mid-wait reset", clk_en, 0);
      chk("R11 core_rst on mid-wait reset", core_rst, 1);
      #1 rst_in = 1'b0;
      count_release(n, 1'b0, 1'b0);
      chk("R2 full sequence after short pulse", n, RST_LAT);
      count_overlap(m, dropped);
      chk("R2 R4 overlap after short pulse", m, OVL);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule